// File: doc/BRIEF.md
# Burst-Synchronous Memory Address Recorder

This block captures a free-running stream of sample words during an accelerator burst and stores them in an external word-addressed memory. There is no trigger. The storage location of each sample depends only on how much time has passed since the start-of-burst pulse, so a sample taken at a given time after the start always lands in the same place. An end-of-burst pulse stops recording. Recording also stops when the configured maximum span is reached, which is either a short or a long burst selected at each start. The stored words stay in memory through the idle gap and are replaced only by the next burst.

A host reads stored data by giving a word offset and a length. The block answers with one response beat per word. Each beat carries a status code and the sequence number of the current burst. The memory port is shared. A sample write always wins the port, and host reads use only the cycles in which no sample is being written. Readout can therefore continue while the next burst records, and the host can spread it over the whole burst period.

Top module: `burst_recorder`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. A request made before any burst is rejected with status 2'b10.
- R2: Each `burst_start` pulse adds one to an 8-bit burst number, which starts at 0 after reset. Every response beat carries the value that number has in the cycle its memory read, or its rejection, is issued.
- R3: The k-th cycle after the `burst_start` edge is time slot k, counting from 0. Slot k belongs to tick k / WORDS_PER_TICK and lane k % WORDS_PER_TICK. When `sample_valid` is 1 in that slot, `sample_data` is written at BASE_ADDR + tick*WORDS_PER_TICK + lane, which equals BASE_ADDR + k.
- R4: The `burst_end` pulse moves the block from recording to holding. The sample in the end cycle is not stored. The recorded length becomes the number of slots that had passed, k.
- R5: `span_long` is sampled at `burst_start`. A value of 0 selects SHORT_TICKS ticks and 1 selects LONG_TICKS ticks. The last slot of the span is still written, and recording then stops on its own with a recorded length of span*WORDS_PER_TICK.
- R6: While holding, each word within the recorded length reads back with status 2'b00 and the value stored in the last burst.
- R7: A host read uses the memory port only in a cycle with no sample write. Its beat appears in the next cycle. Words come in increasing offset order, and `rsp_last` is set on the final beat.
- R8: During recording, a word whose offset is not below the current slot returns status 2'b01 with data 0.
- R9: The block rejects a request when offset + length exceeds a limit. The limit is the configured span while recording, the recorded length while holding, and 0 while idle. A rejected request produces one beat with status 2'b10, data 0 and `rsp_last` set.
- R10: A `burst_start` during recording restarts the burst at slot 0 with a new burst number. When `burst_start` and `burst_end` arrive in the same cycle, the start is taken.
- R11: While a read is in progress `req_ready` is 0, and any `req_valid` in that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Start-of-burst pulse |
| burst_end | input | 1 | End-of-burst pulse |
| span_long | input | 1 | Span select, sampled at start (0 short, 1 long) |
| sample_valid | input | 1 | Sample word present in this slot |
| sample_data | input | DATA_W | Sample word |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Request can be accepted |
| req_off | input | OFF_W | First word offset from the start of the burst |
| req_len_m1 | input | OFF_W | Number of words minus one |
| rsp_valid | output | 1 | Response beat |
| rsp_data | output | DATA_W | Stored word, or 0 unless the status is 2'b00 |
| rsp_status | output | 2 | 00 ok, 01 not yet written, 10 out of span |
| rsp_seq | output | 8 | Burst number |
| rsp_last | output | 1 | Final beat of a request |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read |

## Verification
The sample stream is driven in three patterns.
- A sample in every other slot gives host reads a steady supply of gaps. Reads made during this pattern show how the not-yet-written status is decided against the moving slot counter.
- A sample in every slot starves the read engine. This pattern shows whether writes really keep priority, and whether a pending read waits until the end pulse.
- No samples at all, while holding, lets the persisted contents be read back in full.

The same reference model also covers:
- a span that ends on its own;
- restarts in the middle of a burst, including start and end in the same cycle;
- requests placed exactly at the recorded length and one word beyond it;
- requests presented while a read is in progress.

// File: rtl/burst_rec_pkg.sv
// Shared types for the burst recorder: the burst state and the response status codes.
package burst_rec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_HOLD = 2'd2
    } burst_state_e;

    typedef enum logic [1:0] {
        RSP_OK          = 2'b00,
        RSP_NOT_WRITTEN = 2'b01,
        RSP_OUT_OF_SPAN = 2'b10
    } rsp_status_e;
endpackage

// File: rtl/burst_addr_gen.sv
// Time-to-offset generator. Counts ticks and word lanes inside a tick, so the
// offset is tick*WORDS_PER_TICK + lane.
// Assumes restart and advance are never both set in the same cycle.
module burst_addr_gen #(
    parameter int WORDS_PER_TICK = 4,
    parameter int OFF_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    output logic [OFF_W-1:0] offset
);
    localparam int LANE_W = (WORDS_PER_TICK > 1) ? $clog2(WORDS_PER_TICK) : 1;

    logic [OFF_W-1:0] tick;

    generate
        if (WORDS_PER_TICK > 1) begin : g_lane
            logic [LANE_W-1:0] lane;
            logic              lane_wrap;

            assign lane_wrap = (lane == LANE_W'(WORDS_PER_TICK - 1));

            // Step the lane and carry into the tick at the end of each tick.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    lane <= '0;
                    tick <= '0;
                end else if (advance) begin
                    lane <= lane_wrap ? '0 : lane + 1'b1;
                    if (lane_wrap) tick <= tick + 1'b1;
                end
            end

            assign offset = OFF_W'(tick * WORDS_PER_TICK) + OFF_W'(lane);
        end else begin : g_nolane
            // One word per tick: the tick alone is the offset.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) tick <= '0;
                else if (advance)      tick <= tick + 1'b1;
            end

            assign offset = tick;
        end
    endgenerate
endmodule

// File: rtl/burst_fsm.sv
// Burst state machine: IDLE, RECORDING and HOLD. Keeps the burst number, the
// span chosen at start and the length recorded at stop.
// Start has priority over end. The last slot of the span is written before stopping.
module burst_fsm
    import burst_rec_pkg::*;
#(
    parameter int WORDS_PER_TICK = 4,
    parameter int SHORT_TICKS    = 16,
    parameter int LONG_TICKS     = 32,
    parameter int OFF_W          = 8,
    parameter int SEQ_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start,
    input  logic             burst_end,
    input  logic             span_long,
    input  logic [OFF_W-1:0] offset,
    output burst_state_e     state,
    output logic [SEQ_W-1:0] seq,
    output logic [OFF_W-1:0] max_words,
    output logic [OFF_W-1:0] rec_len,
    output logic             rec_slot,
    output logic             advance
);
    localparam logic [OFF_W-1:0] SHORT_WORDS = OFF_W'(SHORT_TICKS * WORDS_PER_TICK);
    localparam logic [OFF_W-1:0] LONG_WORDS  = OFF_W'(LONG_TICKS * WORDS_PER_TICK);

    logic at_last;

    assign at_last  = (offset == max_words - 1'b1);
    assign rec_slot = (state == ST_REC) && !burst_start && !burst_end;
    assign advance  = rec_slot && !at_last;

    // Burst transitions, burst number, span latch and recorded length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            seq       <= '0;
            max_words <= SHORT_WORDS;
            rec_len   <= '0;
        end else if (burst_start) begin
            state     <= ST_REC;
            seq       <= seq + 1'b1;
            max_words <= span_long ? LONG_WORDS : SHORT_WORDS;
        end else if (state == ST_REC) begin
            if (burst_end) begin
                state   <= ST_HOLD;
                rec_len <= offset;
            end else if (at_last) begin
                state   <= ST_HOLD;
                rec_len <= max_words;
            end
        end
    end
endmodule

// File: rtl/burst_read_engine.sv
// Host read engine. Accepts one request at a time and checks it against the
// span limit. It then issues one word read per free memory slot and registers a response
// beat for each read. Assumes memory read data arrives one cycle after the read.
module burst_read_engine
    import burst_rec_pkg::*;
#(
    parameter int OFF_W = 8,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_off,
    input  logic [OFF_W-1:0] req_len_m1,
    input  logic             slot_free,
    input  logic [OFF_W-1:0] valid_lim,
    input  logic [OFF_W-1:0] span_lim,
    input  logic [SEQ_W-1:0] seq,
    output logic             req_ready,
    output logic             rd_issue,
    output logic [OFF_W-1:0] rd_off,
    output logic             rsp_valid,
    output rsp_status_e      rsp_status,
    output logic             rsp_last,
    output logic [SEQ_W-1:0] rsp_seq
);
    logic             busy;
    logic [OFF_W-1:0] remain;
    logic [OFF_W:0]   req_end;

    assign req_ready = !busy;
    assign rd_issue  = busy && slot_free;
    assign req_end   = {1'b0, req_off} + {1'b0, req_len_m1} + 1'b1;

    // Accept or reject a request, then walk its words and emit one beat per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            rd_off     <= '0;
            remain     <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= RSP_OK;
            rsp_last   <= 1'b0;
            rsp_seq    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            if (rd_issue) begin
                rsp_valid  <= 1'b1;
                rsp_status <= (rd_off < valid_lim) ? RSP_OK : RSP_NOT_WRITTEN;
                rsp_last   <= (remain == '0);
                rsp_seq    <= seq;
                rd_off     <= rd_off + 1'b1;
                remain     <= remain - 1'b1;
                if (remain == '0) busy <= 1'b0;
            end else if (!busy && req_valid) begin
                if (req_end > {1'b0, span_lim}) begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= RSP_OUT_OF_SPAN;
                    rsp_last   <= 1'b1;
                    rsp_seq    <= seq;
                end else begin
                    busy   <= 1'b1;
                    rd_off <= req_off;
                    remain <= req_len_m1;
                end
            end
        end
    end
endmodule

// File: rtl/burst_recorder.sv
// Burst recorder top. Writes each sample at BASE_ADDR plus the time offset since
// start of burst. Serves host reads in slots without a write and returns
// status-tagged beats. Assumes a single-port memory with one-cycle read latency.
module burst_recorder
    import burst_rec_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int ADDR_W         = 16,
    parameter int BASE_ADDR      = 256,
    parameter int WORDS_PER_TICK = 4,
    parameter int SHORT_TICKS    = 16,
    parameter int LONG_TICKS     = 32,
    localparam int OFF_W         = $clog2(LONG_TICKS * WORDS_PER_TICK + 1),
    localparam int SEQ_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              burst_end,
    input  logic              span_long,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [OFF_W-1:0]  req_len_m1,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_status,
    output logic [SEQ_W-1:0]  rsp_seq,
    output logic              rsp_last,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    burst_state_e     state;
    rsp_status_e      status_q;
    logic [SEQ_W-1:0] seq;
    logic [OFF_W-1:0] offset, max_words, rec_len, valid_lim, span_lim, rd_off;
    logic             rec_slot, advance, write_en, rd_issue;

    burst_addr_gen #(
        .WORDS_PER_TICK(WORDS_PER_TICK),
        .OFF_W         (OFF_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(burst_start),
        .advance(advance),
        .offset (offset)
    );

    burst_fsm #(
        .WORDS_PER_TICK(WORDS_PER_TICK),
        .SHORT_TICKS   (SHORT_TICKS),
        .LONG_TICKS    (LONG_TICKS),
        .OFF_W         (OFF_W),
        .SEQ_W         (SEQ_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_start(burst_start),
        .burst_end  (burst_end),
        .span_long  (span_long),
        .offset     (offset),
        .state      (state),
        .seq        (seq),
        .max_words  (max_words),
        .rec_len    (rec_len),
        .rec_slot   (rec_slot),
        .advance    (advance)
    );

    // Valid and span limits the read engine compares against, per burst state.
    always_comb begin
        unique case (state)
            ST_REC: begin
                valid_lim = offset;
                span_lim  = max_words;
            end
            ST_HOLD: begin
                valid_lim = rec_len;
                span_lim  = rec_len;
            end
            default: begin
                valid_lim = '0;
                span_lim  = '0;
            end
        endcase
    end

    assign write_en = rec_slot && sample_valid;

    burst_read_engine #(
        .OFF_W(OFF_W),
        .SEQ_W(SEQ_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_off   (req_off),
        .req_len_m1(req_len_m1),
        .slot_free (!write_en),
        .valid_lim (valid_lim),
        .span_lim  (span_lim),
        .seq       (seq),
        .req_ready (req_ready),
        .rd_issue  (rd_issue),
        .rd_off    (rd_off),
        .rsp_valid (rsp_valid),
        .rsp_status(status_q),
        .rsp_last  (rsp_last),
        .rsp_seq   (rsp_seq)
    );

    assign mem_en     = write_en || rd_issue;
    assign mem_we     = write_en;
    assign mem_addr   = ADDR_W'(BASE_ADDR) + ADDR_W'(write_en ? offset : rd_off);
    assign mem_wdata  = sample_data;
    assign rsp_status = status_q;
    assign rsp_data   = (rsp_valid && status_q == RSP_OK) ? mem_rdata : '0;
endmodule

// File: rtl/burst_recorder_chk.sv
// Property checker for the burst recorder, attached to every instance by bind.
module burst_recorder_chk #(
    parameter int DATA_W         = 16,
    parameter int ADDR_W         = 16,
    parameter int BASE_ADDR      = 256,
    parameter int WORDS_PER_TICK = 4,
    parameter int LONG_TICKS     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_start,
    input logic              burst_end,
    input logic              sample_valid,
    input logic              in_rec,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_last,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int TOP_ADDR = BASE_ADDR + LONG_TICKS * WORDS_PER_TICK;

    // R7: a sampled slot while recording always takes the memory port as a write
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rec && sample_valid && !burst_start && !burst_end) |-> (mem_en && mem_we));

    // R7: every memory read yields a data beat in the next cycle
    a_r7_beat_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (rsp_valid && rsp_status != 2'b10));

    // R4: no sample write outside recording
    a_r4_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rec |-> !(mem_en && mem_we));

    // R3: all accesses stay inside the recording window
    a_r3_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (int'(mem_addr) >= BASE_ADDR && int'(mem_addr) < TOP_ADDR));

    // R8: a not-yet-written beat carries zero data
    a_r8_unwritten_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b01) |-> (rsp_data == '0));

    // R9: a rejection is a single zero beat marked last
    a_r9_reject_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b10) |-> (rsp_last && rsp_data == '0));

    // R11: ready only drops after a request was presented
    a_r11_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));
endmodule

bind burst_recorder burst_recorder_chk #(
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .BASE_ADDR     (BASE_ADDR),
    .WORDS_PER_TICK(WORDS_PER_TICK),
    .LONG_TICKS    (LONG_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .burst_end   (burst_end),
    .sample_valid(sample_valid),
    .in_rec      (state == burst_rec_pkg::ST_REC),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_data    (rsp_data),
    .rsp_last    (rsp_last),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr)
);

// File: tb/burst_recorder_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the recorder, compared on every clock.
module burst_recorder_tb;
    localparam int DW = 16, AW = 16, BASE = 256, WPT = 4, ST = 16, LT = 32;
    localparam int OW = $clog2(LT * WPT + 1);
    localparam int SHORT_W = ST * WPT, LONG_W = LT * WPT;

    logic clk = 0, rst_n = 0;
    logic burst_start = 0, burst_end = 0, span_long = 0;
    logic sample_valid = 0;
    logic [DW-1:0] sample_data = 0;
    logic req_valid = 0, req_ready;
    logic [OW-1:0] req_off = 0, req_len_m1 = 0;
    logic rsp_valid, rsp_last, mem_en, mem_we;
    logic [DW-1:0] rsp_data, mem_wdata;
    logic [DW-1:0] mem_rdata = 0;
    logic [1:0] rsp_status;
    logic [7:0] rsp_seq;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    burst_recorder u_dut (.*);

    // external memory: one-cycle read latency
    logic [DW-1:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
    end

    int checks = 0, bad = 0;
    string tag = "R1";
    bit chk_on = 0;
    int smode = 0;
    int last_seq = 0;

    task automatic check(input bit ok, input string t, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // reference model state
    logic [DW-1:0] ref_mem [0:1023];
    int m_st, m_off, m_seq, m_maxw, m_rlen, m_busy, m_rd, m_rem;
    int lv, ls;
    bit wr;
    bit e_valid, e_last;
    int e_stat, e_seq;
    logic [DW-1:0] e_data;

    initial for (int i = 0; i < 1024; i++) begin mem[i] = 0; ref_mem[i] = 0; end

    // model update from the inputs present before each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_off = 0; m_seq = 0; m_maxw = SHORT_W; m_rlen = 0;
            m_busy = 0; m_rd = 0; m_rem = 0; e_valid = 0; e_last = 0;
            e_stat = 0; e_seq = 0; e_data = 0;
        end else begin
            wr = (m_st == 1) && !burst_start && !burst_end && sample_valid;
            lv = (m_st == 1) ? m_off : (m_st == 2 ? m_rlen : 0);
            ls = (m_st == 1) ? m_maxw : (m_st == 2 ? m_rlen : 0);
            e_valid = 0; e_last = 0; e_data = 0;
            if (m_busy != 0 && !wr) begin
                e_valid = 1; e_seq = m_seq;
                e_stat = (m_rd < lv) ? 0 : 1;
                e_data = (e_stat == 0) ? ref_mem[BASE + m_rd] : 0;
                e_last = (m_rem == 0);
                m_rd++;
                if (m_rem == 0) m_busy = 0; else m_rem--;
            end else if (m_busy == 0 && req_valid) begin
                if (int'(req_off) + int'(req_len_m1) + 1 > ls) begin
                    e_valid = 1; e_stat = 2; e_last = 1; e_seq = m_seq;
                end else begin
                    m_busy = 1; m_rd = int'(req_off); m_rem = int'(req_len_m1);
                end
            end
            if (wr) ref_mem[BASE + m_off] = sample_data;
            if (burst_start) begin
                m_st = 1; m_off = 0; m_seq = (m_seq + 1) % 256;
                m_maxw = span_long ? LONG_W : SHORT_W;
            end else if (m_st == 1) begin
                if (burst_end) begin m_st = 2; m_rlen = m_off; end
                else if (m_off == m_maxw - 1) begin m_st = 2; m_rlen = m_maxw; end
                else m_off++;
            end
        end
    end

    // compare outputs away from the edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(req_ready === (m_busy == 0), tag, "req_ready", req_ready, m_busy == 0);
            if (rsp_valid !== e_valid)
                check(0, tag, "rsp_valid", rsp_valid, e_valid);
            else if (e_valid) begin
                check(rsp_status == 2'(e_stat) && rsp_data == e_data &&
                      rsp_last == e_last && rsp_seq == 8'(e_seq), tag,
                      "beat {status,last,seq,data}",
                      {rsp_status, rsp_last, rsp_seq, rsp_data},
                      {2'(e_stat), e_last, 8'(e_seq), e_data});
                last_seq = int'(rsp_seq);
            end
        end
    end

    // sample stream source
    initial begin
        int scnt = 0;
        forever begin
            @(negedge clk);
            scnt++;
            sample_valid = (smode == 2) || (smode == 1 && scnt[0]);
            sample_data = 16'(scnt * 13 + 5);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_req(input int off, input int lm1);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_off = OW'(off); req_len_m1 = OW'(lm1);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cyc(3);
    endtask

    task automatic pulse_start(input bit lng, input bit with_end);
        span_long = lng; burst_start = 1; burst_end = with_end;
        @(negedge clk);
        burst_start = 0; burst_end = 0;
    endtask

    task automatic pulse_end;
        burst_end = 1;
        @(negedge clk);
        burst_end = 0;
    endtask

    initial begin
        begin : watchdog
            fork
                begin
                    repeat (50000) @(posedge clk);
                    bad++;
                    $display("FAIL watchdog expired");
                    $display("test done: total=%0d bad=%0d", checks, bad);
                    $finish;
                end
            join_none
        end
        cyc(3);
        rst_n = 1;
        cyc(1);
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 0, "R1", "no beat after reset", rsp_valid, 0);
        chk_on = 1;
        tag = "R1"; send_req(0, 0); drain();          // idle request rejected

        // burst 1: short span, sample every other slot
        smode = 1;
        tag = "R2"; pulse_start(0, 0);
        tag = "R8"; send_req(20, 3);                  // ahead of the slot counter
        tag = "R7"; send_req(0, 7);                   // reads in the gaps
        tag = "R9"; send_req(60, 7);                  // beyond configured span
        tag = "R7"; send_req(2, 15);
        tag = "R5"; cyc(80);                          // span ends on its own
        check(m_rlen == SHORT_W, "R5", "recorded length", m_rlen, SHORT_W);
        smode = 0;
        tag = "R6"; send_req(0, SHORT_W - 1); drain();
        tag = "R9"; send_req(SHORT_W - 1, 1); drain();
        tag = "R6"; send_req(SHORT_W - 1, 0); drain();

        // burst 2: long span, every slot sampled, pending read must wait
        smode = 2;
        tag = "R7"; pulse_start(1, 0);
        send_req(0, 3);
        cyc(40);
        tag = "R4"; pulse_end(); smode = 0; drain();
        tag = "R3"; send_req(0, m_rlen - 1); drain();
        tag = "R4"; send_req(m_rlen - 1, 0); drain();
        send_req(m_rlen - 1, 1); drain();

        // burst 3: restarts
        smode = 1;
        tag = "R10"; pulse_start(0, 0);
        cyc(10);
        pulse_start(0, 0);
        cyc(5);
        pulse_start(0, 1);                            // start wins over end
        cyc(6);
        pulse_end(); smode = 0;
        send_req(0, m_rlen - 1); drain();
        check(last_seq == 5, "R2", "burst number after five starts", last_seq, 5);

        // request held while busy is ignored
        tag = "R11"; send_req(0, 5);
        req_valid = 1; req_off = OW'(100); req_len_m1 = 0;
        cyc(3);
        req_valid = 0;
        drain();
        check(req_ready == 1, "R11", "ready after read", req_ready, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule